// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block drives the command bus of one DDR2 SDRAM (x16 organization) from reset until the device can take normal traffic. After reset it keeps CKE low for a short period. It then raises CKE and drives NOP for the power-up settle time. After that it plays a fixed script of commands:

1. precharge-all
2. extended-register write with the DLL enabled
3. mode-register write with DLL reset
4. precharge-all
5. two refreshes
6. mode-register write with DLL reset cleared
7. OCD-default extended write
8. OCD-exit extended write

Every gap is a parameter in clock cycles, and a down-counter enforces it. A separate DLL lock counter starts at the DLL-reset write. The ready flag rises only after this count and the final tOIT wait have both expired. Once the flag is up, it stays up until the next reset.

Every mode-register write is rebuilt in full from the configuration inputs (burst length, burst type, CAS latency, write recovery). The controller's main scheduler is expected to take over the bus once `done_o` is high. ODT stays low for the whole sequence.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `cke_o`=0, `done_o`=0, `odt_o`=0, and the bus carries NOP (`cs_no`=0, `ras_no`=1, `cas_no`=1, `we_no`=1).
- R2: CKE timing.
  - `cke_o` stays low for `T_CKE_LOW` cycles after reset release, then stays high.
  - Exactly `T_PWR` cycles of NOP with CKE high pass before the first command.
  - No command other than NOP is driven while CKE is low.
- R3: Commands are issued one cycle each, in this order: precharge-all, EMRS-DLL, MRS-DLL-reset, precharge-all, refresh, refresh, MRS-run, EMRS-OCD-default, EMRS-OCD-exit.
  - Pin encodings (`cs_no`,`ras_no`,`cas_no`,`we_no`): precharge 0010 with `addr_o[10]`=1 and `ba_o`=0; refresh 0001; mode write 0000.
  - All other cycles are NOP.
- R4: The spacing from one command to the next is fixed by the command just issued: `T_RP` after precharge, `T_MRD` after any mode write except the last, and `T_RFC` after refresh.
- R5: A mode-register write (`ba_o`=00) carries the following address fields:
  - `addr_o[2:0]`=010 for burst 4 or 011 for burst 8 (`cfg_bl8_i`).
  - `addr_o[3]`=`cfg_bt_i`, `addr_o[6:4]`=`cfg_cl_i`, `addr_o[7]`=0.
  - `addr_o[8]`=1 only in the DLL-reset write.
  - `addr_o[11:9]`=`cfg_wr_i`, `addr_o[12]`=0.
- R6: An extended write uses `ba_o`=01 and has every address bit zero except `addr_o[9:7]`, which is 111 for OCD-default and 000 for DLL-enable and OCD-exit. `addr_o[0]`=0 keeps the DLL enabled.
- R7: `done_o` rises in cycle max(E+`T_OIT`, D+`T_DLL_LOCK`)+1. Here E is the OCD-exit cycle and D is the DLL-reset write cycle.
- R8: `odt_o` is low in every cycle, and the address bus is 13 bits wide (no A13).
- R9: Once high, `done_o` stays high and the bus carries NOP with CKE high until reset.
- R10: Asserting `rst_ni` in the middle of the sequence returns the bus at once to the R1 state. After release the whole script restarts from the CKE-low wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_bl8_i | input | 1 | 1 selects burst 8, 0 selects burst 4 |
| cfg_bt_i | input | 1 | Burst type bit |
| cfg_cl_i | input | 3 | CAS latency code |
| cfg_wr_i | input | 3 | Write recovery code |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Address bus A0..A12 |
| odt_o | output | 1 | On-die termination, held low |
| done_o | output | 1 | Initialization complete, sticky |

## Verification
The assertions check a set of properties on every cycle:
- NOP is the only command while CKE is low.
- Mode writes see CKE already high.
- No two commands are closer than the smallest gap.
- The test bit is clear and the burst code is legal in every mode write.
- The DLL-enable bit is zero in extended writes.
- The ready flag is sticky and never rises before the DLL lock count.

Only the bench scenarios can show that the exact script order and the exact gap after each command match. They also show that the mode words follow several random configurations, and that a reset in the middle of the sequence restarts the script from the beginning.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    ST_CKE_LOW,
    ST_PWR_WAIT,
    ST_PREA0,
    ST_EMR_DLL,
    ST_MR_DLLRST,
    ST_PREA1,
    ST_REF0,
    ST_REF1,
    ST_MR_RUN,
    ST_EMR_OCDDEF,
    ST_EMR_OCDEXIT,
    ST_OIT_WAIT,
    ST_READY
  } step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam pins_t PINS_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam pins_t PINS_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam pins_t PINS_MODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  function automatic logic is_cmd_step(step_e s);
    return (s >= ST_PREA0) && (s <= ST_EMR_OCDEXIT);
  endfunction

endpackage

// File: rtl/ddr2_init_words.sv
module ddr2_init_words
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  step_e             step_i,
  input  logic              issue_i,
  input  logic              cfg_bl8_i,
  input  logic              cfg_bt_i,
  input  logic [2:0]        cfg_cl_i,
  input  logic [2:0]        cfg_wr_i,
  output pins_t             pins_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int A_PREA_ALL = 10;

  logic [ADDR_W-1:0] mr_word;
  logic [ADDR_W-1:0] emr_word;
  logic              dll_rst;
  logic [2:0]        ocd_field;

  // full register images rebuilt on every write
  always_comb begin
    dll_rst   = (step_i == ST_MR_DLLRST);
    ocd_field = (step_i == ST_EMR_OCDDEF) ? 3'b111 : 3'b000;

    mr_word       = '0;
    mr_word[2:0]  = cfg_bl8_i ? 3'b011 : 3'b010;
    mr_word[3]    = cfg_bt_i;
    mr_word[6:4]  = cfg_cl_i;
    mr_word[7]    = 1'b0;
    mr_word[8]    = dll_rst;
    mr_word[11:9] = cfg_wr_i;

    emr_word      = '0;
    emr_word[9:7] = ocd_field;
  end

  always_comb begin
    pins_o = PINS_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (issue_i) begin
      unique case (step_i)
        ST_PREA0, ST_PREA1: begin
          pins_o             = PINS_PREA;
          addr_o[A_PREA_ALL] = 1'b1;
        end
        ST_REF0, ST_REF1: pins_o = PINS_REF;
        ST_MR_DLLRST, ST_MR_RUN: begin
          pins_o = PINS_MODE;
          addr_o = mr_word;
        end
        ST_EMR_DLL, ST_EMR_OCDDEF, ST_EMR_OCDEXIT: begin
          pins_o = PINS_MODE;
          ba_o   = BA_W'(1);
          addr_o = emr_word;
        end
        default: pins_o = PINS_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int          CW      = 8,
  parameter int          LW      = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o,
  input  logic          lock_arm_i,
  input  logic [LW-1:0] lock_val_i,
  output logic          lock_done_o
);

  logic [CW-1:0] cnt_q;
  logic [LW-1:0] lock_q;
  logic          armed_q;

  // gap counter: loaded per command, runs down through NOP cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= CW'(RST_VAL);
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= '0;
      armed_q <= 1'b0;
    end else if (lock_arm_i) begin
      lock_q  <= lock_val_i;
      armed_q <= 1'b1;
    end else if (lock_q != '0) begin
      lock_q  <= lock_q - 1'b1;
    end
  end

  assign zero_o      = (cnt_q == '0);
  assign lock_done_o = armed_q && (lock_q == '0);

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int T_CKE_LOW  = 4,
  parameter int T_PWR      = 40,
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 11,
  parameter int T_OIT      = 3,
  parameter int T_DLL_LOCK = 200,
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_bl8_i,
  input  logic              cfg_bt_i,
  input  logic [2:0]        cfg_cl_i,
  input  logic [2:0]        cfg_wr_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              odt_o,
  output logic              done_o
);

  localparam int MAX_A = (T_PWR > T_RFC) ? T_PWR : T_RFC;
  localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_C = (T_OIT > T_CKE_LOW) ? T_OIT : T_CKE_LOW;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_G = (MAX_D > MAX_C) ? MAX_D : MAX_C;
  localparam int CW    = $clog2(MAX_G + 1);
  localparam int LW    = $clog2(T_DLL_LOCK + 1);

  step_e         step_q, step_d;
  logic          zero, lock_done, load, lock_arm, issue;
  logic [CW-1:0] load_val;
  pins_t         pins;

  function automatic logic [CW-1:0] gap_after(step_e s);
    unique case (s)
      ST_PREA0, ST_PREA1: return CW'(T_RP - 1);
      ST_REF0, ST_REF1:   return CW'(T_RFC - 1);
      ST_EMR_OCDEXIT:     return CW'(T_OIT - 1);
      default:            return CW'(T_MRD - 1);
    endcase
  endfunction

  always_comb begin
    step_d   = step_q;
    load     = 1'b0;
    load_val = '0;
    lock_arm = 1'b0;
    unique case (step_q)
      ST_CKE_LOW: if (zero) begin
        step_d   = ST_PWR_WAIT;
        load     = 1'b1;
        load_val = CW'(T_PWR - 1);
      end
      ST_PWR_WAIT: if (zero) step_d = ST_PREA0;
      ST_OIT_WAIT: if (zero && lock_done) step_d = ST_READY;
      ST_READY:    step_d = ST_READY;
      default: if (zero) begin
        step_d   = step_e'(step_q + 4'd1);
        load     = 1'b1;
        load_val = gap_after(step_q);
        lock_arm = (step_q == ST_MR_DLLRST);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_CKE_LOW;
    else         step_q <= step_d;
  end

  ddr2_init_timer #(
    .CW      (CW),
    .LW      (LW),
    .RST_VAL (T_CKE_LOW - 1)
  ) timer_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_val_i  (load_val),
    .zero_o      (zero),
    .lock_arm_i  (lock_arm),
    .lock_val_i  (LW'(T_DLL_LOCK - 1)),
    .lock_done_o (lock_done)
  );

  assign issue = is_cmd_step(step_q) && zero;

  ddr2_init_words #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) words_i (
    .step_i    (step_q),
    .issue_i   (issue),
    .cfg_bl8_i (cfg_bl8_i),
    .cfg_bt_i  (cfg_bt_i),
    .cfg_cl_i  (cfg_cl_i),
    .cfg_wr_i  (cfg_wr_i),
    .pins_o    (pins),
    .ba_o      (ba_o),
    .addr_o    (addr_o)
  );

  assign cs_no  = pins.cs_n;
  assign ras_no = pins.ras_n;
  assign cas_no = pins.cas_n;
  assign we_no  = pins.we_n;
  assign cke_o  = (step_q != ST_CKE_LOW);
  assign odt_o  = 1'b0;
  assign done_o = (step_q == ST_READY);

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 11,
  parameter int T_DLL_LOCK = 200,
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_o,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);

  localparam int MIN_AB  = (T_RP < T_MRD) ? T_RP : T_MRD;
  localparam int MIN_GAP = (MIN_AB < T_RFC) ? MIN_AB : T_RFC;

  logic        is_nop, is_cmd, mode_wr, dll_rst_wr, dll_seen_q;
  logic [15:0] since_cmd_q, since_dll_q;

  assign is_nop     = !cs_no && ras_no && cas_no && we_no;
  assign is_cmd     = !cs_no && !is_nop;
  assign mode_wr    = !cs_no && !ras_no && !cas_no && !we_no;
  assign dll_rst_wr = mode_wr && (ba_o == '0) && addr_o[8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_cmd_q <= 16'hFFFF;
      since_dll_q <= '0;
      dll_seen_q  <= 1'b0;
    end else begin
      if (is_cmd)                     since_cmd_q <= 16'd1;
      else if (since_cmd_q != 16'hFFFF) since_cmd_q <= since_cmd_q + 16'd1;
      if (dll_rst_wr) begin
        since_dll_q <= 16'd1;
        dll_seen_q  <= 1'b1;
      end else if (since_dll_q != 16'hFFFF) begin
        since_dll_q <= since_dll_q + 16'd1;
      end
    end
  end

  AST_CKE_LOW_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> is_nop);  // R2
  AST_MODE_CKE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |-> (cke_o && $past(cke_o)));  // R2
  AST_MIN_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmd |-> (32'(since_cmd_q) >= MIN_GAP));  // R4
  AST_MR_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr && ba_o == '0) |-> (!addr_o[7] && addr_o[2:1] == 2'b01));  // R5
  AST_EMR_DLL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr && ba_o == BA_W'(1)) |-> !addr_o[0]);  // R6
  AST_DONE_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (dll_seen_q && 32'(since_dll_q) > T_DLL_LOCK));  // R7
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);  // R9
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (is_nop && cke_o));  // R9

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
  .T_RP       (T_RP),
  .T_MRD      (T_MRD),
  .T_RFC      (T_RFC),
  .T_DLL_LOCK (T_DLL_LOCK),
  .ADDR_W     (ADDR_W),
  .BA_W       (BA_W)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cke_o  (cke_o),
  .cs_no  (cs_no),
  .ras_no (ras_no),
  .cas_no (cas_no),
  .we_no  (we_no),
  .ba_o   (ba_o),
  .addr_o (addr_o),
  .done_o (done_o)
);

// File: tb/ddr2_init_seq_tb_top.sv
module ddr2_init_seq_tb_top;

  localparam int T_CKE_LOW  = 4;
  localparam int T_PWR      = 40;
  localparam int T_RP       = 3;
  localparam int T_MRD      = 2;
  localparam int T_RFC      = 11;
  localparam int T_OIT      = 3;
  localparam int T_DLL_LOCK = 200;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_bl8_i = 1'b0, cfg_bt_i = 1'b0;
  logic [2:0]  cfg_cl_i = 3'd3, cfg_wr_i = 3'd2;
  logic        cke_o, cs_no, ras_no, cas_no, we_no, odt_o, done_o;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  ddr2_init_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_bl8_i(cfg_bl8_i), .cfg_bt_i(cfg_bt_i),
    .cfg_cl_i(cfg_cl_i), .cfg_wr_i(cfg_wr_i), .cke_o(cke_o), .cs_no(cs_no),
    .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no), .ba_o(ba_o), .addr_o(addr_o),
    .odt_o(odt_o), .done_o(done_o)
  );

  // script cycles, counted from the first sample after reset release
  int cmd_at[9];
  int gaps[9] = '{T_RP, T_MRD, T_MRD, T_RP, T_RFC, T_RFC, T_MRD, T_MRD, T_OIT};
  int done_at;

  function automatic void plan_script();
    cmd_at[0] = T_CKE_LOW + T_PWR;
    for (int i = 1; i < 9; i++) cmd_at[i] = cmd_at[i-1] + gaps[i-1];
    done_at = ((cmd_at[8] + T_OIT) > (cmd_at[2] + T_DLL_LOCK) ?
               (cmd_at[8] + T_OIT) : (cmd_at[2] + T_DLL_LOCK)) + 1;
  endfunction

  function automatic logic [12:0] mr_exp(logic dll);
    return {1'b0, cfg_wr_i, dll, 1'b0, cfg_cl_i, cfg_bt_i, cfg_bl8_i ? 3'b011 : 3'b010};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_cycle(input int k);
    logic [3:0]  pe;
    logic [1:0]  be;
    logic [12:0] ae;
    int          idx;
    string       tag;
    pe = 4'b0111; be = 2'b00; ae = '0; idx = -1; tag = "R3";
    for (int i = 0; i < 9; i++) if (cmd_at[i] == k) idx = i;
    case (idx)
      0, 3: begin pe = 4'b0010; ae[10] = 1'b1; tag = "R3,R4 PREA"; end
      4, 5: begin pe = 4'b0001; tag = "R3,R4 REF"; end
      2:    begin pe = 4'b0000; ae = mr_exp(1'b1); tag = "R5 MR dllrst"; end
      6:    begin pe = 4'b0000; ae = mr_exp(1'b0); tag = "R5 MR run"; end
      1:    begin pe = 4'b0000; be = 2'b01; tag = "R6 EMR dll"; end
      7:    begin pe = 4'b0000; be = 2'b01; ae[9:7] = 3'b111; tag = "R6 EMR ocd default"; end
      8:    begin pe = 4'b0000; be = 2'b01; tag = "R6 EMR ocd exit"; end
      default: tag = (k == 0) ? "R1 nop" : (k >= done_at ? "R9 nop" : "R3 nop");
    endcase
    chk(cke_o === (k >= T_CKE_LOW), (k == 0) ? "R1 cke" : "R2 cke", cke_o, k >= T_CKE_LOW);
    chk({cs_no, ras_no, cas_no, we_no} === pe, tag, {cs_no, ras_no, cas_no, we_no}, pe);
    chk({ba_o, addr_o} === {be, ae}, tag, {ba_o, addr_o}, {be, ae});
    chk(odt_o === 1'b0, "R8 odt", odt_o, 0);
    chk(done_o === (k >= done_at), (k >= done_at) ? "R9 done" : "R7 done", done_o, k >= done_at);
  endtask

  task automatic run_seq(input int abort_at);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    for (int k = 0; k <= done_at + 6; k++) begin
      if (k > 0) begin
        @(negedge clk_i);
        #1;
      end
      if (k == abort_at) begin
        rst_ni = 1'b0;
        #1;
        chk(!cke_o && !done_o && !odt_o, "R10 reset cke/done", {cke_o, done_o}, 0);
        chk({cs_no, ras_no, cas_no, we_no} === 4'b0111, "R10 reset nop",
            {cs_no, ras_no, cas_no, we_no}, 4'b0111);
        return;
      end
      check_cycle(k);
    end
  endtask

  initial begin
    void'($urandom(32'd2025));
    plan_script();
    #2;
    chk(!cke_o && !done_o && !odt_o, "R1 in reset", {cke_o, done_o, odt_o}, 0);
    chk({cs_no, ras_no, cas_no, we_no} === 4'b0111, "R1 in reset nop",
        {cs_no, ras_no, cas_no, we_no}, 4'b0111);
    // directed: burst 4 / burst 8 extremes
    cfg_bl8_i = 1'b0; cfg_bt_i = 1'b0; cfg_cl_i = 3'd2; cfg_wr_i = 3'd1;
    run_seq(-1);
    cfg_bl8_i = 1'b1; cfg_bt_i = 1'b1; cfg_cl_i = 3'd7; cfg_wr_i = 3'd7;
    run_seq(-1);
    // R10: reset during the lock wait, then a full restart
    run_seq(cmd_at[4] + 1);
    run_seq(-1);
    for (int r = 0; r < 5; r++) begin
      cfg_bl8_i = 1'($urandom);
      cfg_bt_i  = 1'($urandom);
      cfg_cl_i  = 3'($urandom);
      cfg_wr_i  = 3'($urandom);
      if (r == 2) run_seq(5 + int'($urandom % 30));
      run_seq(-1);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule